// File: doc/BRIEF.md
# Activity-Reloaded Watchdog Timer

This block is a 16-bit watchdog down-counter that is set up through four byte-wide registers on a simple synchronous byte bus. The counter steps down once per pulse of one of two external tick enables. One tick is a one-per-second pulse and the other is a one-per-minute pulse. A configuration bit picks which tick the counter follows. Software arms the counter by writing the count, high byte first and then low byte, and it stops the counter by writing a count of zero.

Besides software reloads, four activity inputs can reload the counter without any software action. These are infrared receive, mouse, keyboard and game-port access, and each has its own enable bit. When the counter reaches zero, or when software forces a timeout, a sticky expired flag is set. The block can then drive a 16-cycle keyboard-reset pulse, a 16-cycle power-good drop pulse and a level timeout output. The block also passes out a 4-bit interrupt line selection. Producing the tick enables and routing the interrupt are left to the surrounding logic.

Top module: `activity_watchdog`

## Requirements
- R1: After reset, all four registers read 0, and kbdRstOut, pwrDropOut and toutOut are low.
- R2: A write to offset 0x74 stores the high count byte without changing the counter. A write to offset 0x73 loads {stored high byte, written byte} into the counter and keeps it as the reload value. Reads of 0x73 and 0x74 return the low and high bytes of the live counter.
- R3: A nonzero counter decrements by one on each pulse of the selected tick. Configuration (offset 0x72) bit 7 = 1 selects secTick and bit 7 = 0 selects minTick. The unselected tick has no effect.
- R4: The tick that takes the counter from 1 to 0 sets the expired flag, which reads as bit 0 of offset 0x71. After that, the counter stays at 0 on further ticks.
- R5: A write to offset 0x71 with bit 0 = 0 clears the expired flag. Writing bit 0 = 1 neither sets nor clears it.
- R6: A write to offset 0x71 with bit 1 = 1 forces an expiry on that clock edge: the counter becomes 0 and the flag is set. Bit 1 always reads back as 0.
- R7: Control bits 7, 6, 5 and 4 enable reload from irEvent, mouseEvent, kbdEvent and gameEvent in that order. An enabled event pulse reloads a nonzero counter with the reload value. A disabled event, or any event while the counter is 0, is ignored.
- R8: Loading a count of zero stops the watchdog, so later ticks neither change the counter nor set the flag.
- R9: On expiry, kbdRstOut is high for exactly 16 clock cycles if configuration bit 6 is set, and pwrDropOut is high for exactly 16 cycles if bit 4 is set. Otherwise each stays low.
- R10: toutOut equals the expired flag ANDed with configuration bit 5, and irqSel equals configuration bits 3:0. The configuration register reads back as written.
- R11: When a register load or an enabled event reload falls on the same cycle as a tick, the reload value wins and no decrement happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register offset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| secTick | input | 1 | One-cycle pulse per second |
| minTick | input | 1 | One-cycle pulse per minute |
| irEvent | input | 1 | Infrared receive activity pulse |
| mouseEvent | input | 1 | Mouse activity pulse |
| kbdEvent | input | 1 | Keyboard activity pulse |
| gameEvent | input | 1 | Game-port access pulse |
| kbdRstOut | output | 1 | Keyboard-reset pulse on expiry |
| pwrDropOut | output | 1 | Power-good drop pulse on expiry |
| toutOut | output | 1 | Level timeout output |
| irqSel | output | 4 | Selected interrupt line |

## Verification
The assertions assume that the tick and event inputs are synchronous pulses and that each bus write lasts exactly one cycle. The bench drives every input on the falling edge and holds each pulse for a single cycle to stay within these limits. In the priority tests, the bench puts a tick on the same cycle as a load or an event reload. It sweeps load values 1 to 5 in seconds mode, runs a minute-mode case, and walks every event with its enable both on and off. All expected counts are computed arithmetically from the number of ticks applied.

// File: rtl/wdtu_pkg.sv
package wdtu_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef struct packed {
    logic wrLo;    // load counter and reload value
    logic wrHi;    // store high byte
    logic reload;  // event reload
    logic dec;     // tick decrement
    logic clear;   // forced expiry
  } dpStrobe_t;
endpackage

// File: rtl/wdtu_datapath.sv
module wdtu_datapath
  import wdtu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic              countZero,
  output logic              countOne
);
  logic [BYTE_W-1:0] hiShadow;
  logic [CNT_W-1:0]  reloadVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiShadow  <= '0;
      reloadVal <= '0;
      count     <= '0;
    end else begin
      if (stb.wrHi) hiShadow <= wdata;
      if (stb.wrLo) begin
        count     <= {hiShadow, wdata};
        reloadVal <= {hiShadow, wdata};
      end else if (stb.clear) begin
        count <= '0;
      end else if (stb.reload) begin
        count <= reloadVal;
      end else if (stb.dec) begin
        count <= count - CNT_W'(1);
      end
    end
  end

  assign countZero = (count == '0);
  assign countOne  = (count == CNT_W'(1));

  // R3: a decrement is only requested on a running counter
  assert_dec_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.dec |-> !countZero);
  // R8: a stopped counter stays stopped until loaded
  assert_stopped_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (countZero && !stb.wrLo) |=> countZero);
  // R2: the counter only grows through a load or a reload
  assert_no_growth_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrLo || stb.reload) |=> (count <= $past(count)));
endmodule

// File: rtl/wdtu_ctrl.sv
module wdtu_ctrl
  import wdtu_pkg::*;
#(
  parameter logic [7:0] CTL_ADDR  = 8'h71,
  parameter logic [7:0] CFG_ADDR  = 8'h72,
  parameter logic [7:0] LO_ADDR   = 8'h73,
  parameter logic [7:0] HI_ADDR   = 8'h74,
  parameter int         PULSE_LEN = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWe,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              secTick,
  input  logic              minTick,
  input  logic [3:0]        events,     // {ir, mouse, kbd, game}
  input  logic [CNT_W-1:0]  count,
  input  logic              countZero,
  input  logic              countOne,
  output dpStrobe_t         stb,
  output logic              kbdRstOut,
  output logic              pwrDropOut,
  output logic              toutOut,
  output logic [3:0]        irqSel
);
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);

  logic [3:0]        evtEn;
  logic [BYTE_W-1:0] cfg;
  logic              status;
  logic [PULSE_W-1:0] pulseCnt;
  logic wrCtl, wrCfg, forceNow, tickSel, expireNow, pulseActive;

  assign wrCtl    = busWe && (busAddr == CTL_ADDR);
  assign wrCfg    = busWe && (busAddr == CFG_ADDR);
  assign forceNow = wrCtl && busWdata[1];
  assign tickSel  = cfg[7] ? secTick : minTick;

  always_comb begin
    stb.wrLo   = busWe && (busAddr == LO_ADDR);
    stb.wrHi   = busWe && (busAddr == HI_ADDR);
    stb.clear  = forceNow;
    stb.reload = (|(evtEn & events)) && !countZero && !forceNow;
    stb.dec    = tickSel && !countZero && !stb.reload && !stb.wrLo && !forceNow;
  end

  assign expireNow = forceNow || (stb.dec && countOne);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtEn    <= '0;
      cfg      <= '0;
      status   <= 1'b0;
      pulseCnt <= '0;
    end else begin
      if (wrCtl) evtEn <= busWdata[7:4];
      if (wrCfg) cfg <= busWdata;
      if (expireNow)                  status <= 1'b1;
      else if (wrCtl && !busWdata[0]) status <= 1'b0;
      if (expireNow)              pulseCnt <= PULSE_W'(PULSE_LEN);
      else if (pulseCnt != '0)    pulseCnt <= pulseCnt - PULSE_W'(1);
    end
  end

  assign pulseActive = (pulseCnt != '0);
  assign kbdRstOut   = pulseActive && cfg[6];
  assign pwrDropOut  = pulseActive && cfg[4];
  assign toutOut     = status && cfg[5];
  assign irqSel      = cfg[3:0];

  always_comb begin
    case (busAddr)
      CTL_ADDR: busRdata = {evtEn, 3'b000, status};
      CFG_ADDR: busRdata = cfg;
      LO_ADDR:  busRdata = count[BYTE_W-1:0];
      HI_ADDR:  busRdata = count[CNT_W-1:BYTE_W];
      default:  busRdata = '0;
    endcase
  end

  // R5: the flag only drops after a control write
  assert_flag_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status) |-> $past(wrCtl));
  // R6: a forced timeout sets the flag on the next cycle
  assert_force_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    forceNow |=> status);
  // R4: the output pulse only starts together with a set flag
  assert_pulse_with_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> status);
  // R9: the pulse counter never holds beyond its window
  assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && !expireNow) |=> (pulseCnt < $past(pulseCnt)));
endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog
  import wdtu_pkg::*;
#(
  parameter logic [7:0] CTL_ADDR  = 8'h71,
  parameter logic [7:0] CFG_ADDR  = 8'h72,
  parameter logic [7:0] LO_ADDR   = 8'h73,
  parameter logic [7:0] HI_ADDR   = 8'h74,
  parameter int         PULSE_LEN = 16
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busWe,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       secTick,
  input  logic       minTick,
  input  logic       irEvent,
  input  logic       mouseEvent,
  input  logic       kbdEvent,
  input  logic       gameEvent,
  output logic       kbdRstOut,
  output logic       pwrDropOut,
  output logic       toutOut,
  output logic [3:0] irqSel
);
  dpStrobe_t        stb;
  logic [CNT_W-1:0] count;
  logic             countZero, countOne;

  wdtu_ctrl #(
    .CTL_ADDR(CTL_ADDR), .CFG_ADDR(CFG_ADDR), .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR), .PULSE_LEN(PULSE_LEN)
  ) ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .secTick(secTick),
    .minTick(minTick), .events({irEvent, mouseEvent, kbdEvent, gameEvent}),
    .count(count), .countZero(countZero), .countOne(countOne), .stb(stb),
    .kbdRstOut(kbdRstOut), .pwrDropOut(pwrDropOut), .toutOut(toutOut),
    .irqSel(irqSel)
  );

  wdtu_datapath dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .count(count), .countZero(countZero), .countOne(countOne)
  );
endmodule

// File: tb/activity_watchdog_test.sv
module activity_watchdog_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0, busRdata;
  logic busWe = 1'b0, secTick = 1'b0, minTick = 1'b0;
  logic [3:0] evts = '0;   // {ir, mouse, kbd, game}
  logic kbdRstOut, pwrDropOut, toutOut;
  logic [3:0] irqSel;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  activity_watchdog uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .secTick(secTick),
    .minTick(minTick), .irEvent(evts[3]), .mouseEvent(evts[2]),
    .kbdEvent(evts[1]), .gameEvent(evts[0]), .kbdRstOut(kbdRstOut),
    .pwrDropOut(pwrDropOut), .toutOut(toutOut), .irqSel(irqSel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    busAddr = a; #1; v = int'(busRdata);
  endtask

  task automatic cnt(output int v);
    int lo, hi;
    rd(8'h73, lo); rd(8'h74, hi); v = hi * 256 + lo;
  endtask

  task automatic load(input int v);
    wr(8'h74, 8'(v >> 8)); wr(8'h73, 8'(v));
  endtask

  task automatic tick(input bit sec);
    @(negedge clk); if (sec) secTick = 1'b1; else minTick = 1'b1;
    @(negedge clk); secTick = 1'b0; minTick = 1'b0;
  endtask

  task automatic evt(input int i);
    @(negedge clk); evts[i] = 1'b1;
    @(negedge clk); evts = '0;
  endtask

  task automatic pulses(output int nk, output int np);
    nk = 0; np = 0;
    repeat (20) begin
      if (kbdRstOut) nk++;
      if (pwrDropOut) np++;
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, nk, np;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 8'h71; a <= 8'h74; a++) begin rd(8'(a), v); chk("R1 reg", v, 0); end
    chk("R1 outs", {kbdRstOut, pwrDropOut, toutOut}, 0);
    // R2 high byte held, low byte loads
    wr(8'h74, 8'h12); cnt(v); chk("R2 hi alone", v, 0);
    wr(8'h73, 8'h34); cnt(v); chk("R2 load", v, 16'h1234);
    wr(8'h74, 8'h00); cnt(v); chk("R2 hi no load", v, 16'h1234);
    // R3 R4 R9 seconds sweep with keyboard reset
    wr(8'h72, 8'hC0);
    for (int n = 1; n <= 5; n++) begin
      wr(8'h71, 8'h00);
      load(n);
      for (int k = 1; k < n; k++) begin
        tick(1'b1); cnt(v); chk("R3 sec dec", v, n - k);
        tick(1'b0); cnt(v); chk("R3 min ignored", v, n - k);
        rd(8'h71, v); chk("R4 not yet", v & 1, 0);
      end
      tick(1'b1);
      rd(8'h71, v); chk("R4 flag", v & 1, 1);
      cnt(v); chk("R4 zero", v, 0);
      pulses(nk, np);
      chk("R9 kbd len", nk, 16); chk("R9 pwr off", np, 0);
      tick(1'b1); cnt(v); chk("R4 stays zero", v, 0);
    end
    // minute mode with power-good drop
    wr(8'h71, 8'h00); wr(8'h72, 8'h10); load(2);
    tick(1'b1); cnt(v); chk("R3 sec ignored", v, 2);
    tick(1'b0); cnt(v); chk("R3 min dec", v, 1);
    tick(1'b0); rd(8'h71, v); chk("R4 min flag", v & 1, 1);
    pulses(nk, np);
    chk("R9 kbd off", nk, 0); chk("R9 pwr len", np, 16);
    // R10
    chk("R10 tout off", toutOut, 0);
    wr(8'h72, 8'h35); chk("R10 tout on", toutOut, 1); chk("R10 irq", irqSel, 5);
    rd(8'h72, v); chk("R10 readback", v, 8'h35);
    // R5
    wr(8'h71, 8'h01); rd(8'h71, v); chk("R5 write 1 keeps", v & 1, 1);
    wr(8'h71, 8'h00); rd(8'h71, v); chk("R5 clear", v & 1, 0);
    chk("R10 tout follows", toutOut, 0);
    wr(8'h71, 8'h01); rd(8'h71, v); chk("R5 write 1 no set", v & 1, 0);
    // R6
    wr(8'h72, 8'h80); load(100);
    wr(8'h71, 8'h02); cnt(v); chk("R6 count", v, 0);
    rd(8'h71, v); chk("R6 flag and bit1", v, 1);
    // R7
    for (int i = 0; i < 4; i++) begin
      for (int en = 0; en < 2; en++) begin
        wr(8'h71, en ? 8'(1 << (4 + i)) : 8'h00);
        load(10);
        repeat (3) tick(1'b1);
        evt(i); cnt(v);
        chk("R7 event", v, en ? 10 : 7);
      end
    end
    wr(8'h71, 8'hF0); load(0);
    for (int i = 0; i < 4; i++) evt(i);
    cnt(v); chk("R7 zero ignores", v, 0);
    // R8
    load(5); load(0);
    repeat (10) tick(1'b1);
    cnt(v); chk("R8 stopped", v, 0);
    rd(8'h71, v); chk("R8 no flag", v & 1, 0);
    // R11 event vs tick, load vs tick
    wr(8'h71, 8'h10); load(3); tick(1'b1);
    @(negedge clk); secTick = 1'b1; evts[0] = 1'b1;
    @(negedge clk); secTick = 1'b0; evts = '0;
    cnt(v); chk("R11 event wins", v, 3);
    @(negedge clk); busAddr = 8'h73; busWdata = 8'h09; busWe = 1'b1; secTick = 1'b1;
    @(negedge clk); busWe = 1'b0; secTick = 1'b0;
    cnt(v); chk("R11 load wins", v, 9);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule